// File: doc/BRIEF.md
# LC-3 Register Select and Effective Address Unit

A combinational decode and address unit for a 16-bit LC-3 style datapath. From the instruction register, the already incremented PC and the value read on the first source port, it forms the destination register number, the first source register number and an effective address. A decoded instruction class from the sequencer picks every mux select in the unit. The block also drives those selects out so the rest of the datapath can follow them.

The address is a base-plus-offset sum. The base is either the PC or the source register value. The offset is zero or one of three sign-extended immediate fields. The sum feeds two paths: the memory address path and the PC load path. Each path has its own enable, and the two enables are never raised together. For a trap, the memory address path takes the zero-extended 8-bit vector in place of the sum. The link register R7 can be forced as the destination for calls and traps. Stores read their data register through the first source port.

Top module: `lc3_agu`

## Requirements
- R1: `dr_sel_o` is 1 and `dr_o` is 3'b111 for the JSR (3), JSRR (4) and TRAP (9) classes. For every other class, `dr_sel_o` is 0 and `dr_o` equals IR[11:9].
- R2: `sr1_sel_o` is 1 and `sr1_o` equals IR[11:9] for the ST class (7). For every other class, `sr1_sel_o` is 0 and `sr1_o` equals IR[8:6].
- R3: `base_sel_o` is 1 for the JMP (2), JSRR (4), LDR (6) and STR (8) classes, and the base is then `sr1_val_i`. For every other class, `base_sel_o` is 0 and the base is `pc_i`.
- R4: `ofs_sel_o` encodes the offset as follows:
  - 0: zero, for ALU (0), JMP, JSRR and TRAP.
  - 1: sign-extended IR[5:0], for LDR and STR.
  - 2: sign-extended IR[8:0], for BR (1), LD (5), ST and LEA (10).
  - 3: sign-extended IR[10:0], for JSR.
- R5: `sum_o` equals base plus the selected offset, taken modulo 2^16. Both positive and negative offsets wrap.
- R6: For the TRAP class, `mar_sel_o` is 1 and `mar_addr_o` equals the zero-extended IR[7:0]. Otherwise `mar_sel_o` is 0 and `mar_addr_o` equals `sum_o`.
- R7: `mar_en_o` is 1 only for the LD, LDR, ST, STR and TRAP classes. `pc_ld_o` is 1 only for the BR, JMP, JSR and JSRR classes. The two are never both 1.
- R8: The ALU and LEA classes, and the unused class codes 11 to 15, raise neither enable. The unused codes behave exactly like the ALU class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cls_i | input | 4 | Decoded instruction class |
| ir_i | input | 16 | Instruction register |
| pc_i | input | 16 | Incremented program counter |
| sr1_val_i | input | 16 | Value read on first source port |
| dr_o | output | 3 | Destination register number |
| sr1_o | output | 3 | First source register number |
| dr_sel_o | output | 1 | Destination mux select (1 = R7) |
| sr1_sel_o | output | 1 | Source mux select (1 = IR[11:9]) |
| base_sel_o | output | 1 | Base mux select (1 = source register) |
| ofs_sel_o | output | 2 | Offset mux select |
| mar_sel_o | output | 1 | Memory address mux select (1 = trap vector) |
| sum_o | output | 16 | Base plus offset sum |
| mar_addr_o | output | 16 | Address on memory path |
| mar_en_o | output | 1 | Memory address path enable |
| pc_ld_o | output | 1 | PC load enable |

## Verification
The hardest behaviour to bring about is a carry out of bit 15. It needs a base near either end of the address space together with an offset of the right sign. The vectors pair PC 0x0100 with the most negative 11-bit offset, and a source value of 0xFFF0 with a positive 6-bit offset, so the sum wraps in both directions. The trap vector is checked at a low code and at 0xFF, with a PC that differs from both. Undefined class codes are driven with a store-like IR, which shows that no enable rises and the source field stays IR[8:6].

// File: rtl/lc3_agu_pkg.sv
package lc3_agu_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU  = 4'd0,
    CLS_BR   = 4'd1,
    CLS_JMP  = 4'd2,
    CLS_JSR  = 4'd3,
    CLS_JSRR = 4'd4,
    CLS_LD   = 4'd5,
    CLS_LDR  = 4'd6,
    CLS_ST   = 4'd7,
    CLS_STR  = 4'd8,
    CLS_TRAP = 4'd9,
    CLS_LEA  = 4'd10
  } instr_cls_e;

  typedef enum logic [1:0] {
    OFS_ZERO = 2'd0,
    OFS_6    = 2'd1,
    OFS_9    = 2'd2,
    OFS_11   = 2'd3
  } ofs_sel_e;

  typedef struct packed {
    logic     dr_link;
    logic     sr1_hi;
    logic     base_reg;
    ofs_sel_e ofs;
    logic     mar_vec;
    logic     mar_en;
    logic     pc_ld;
  } agu_ctl_t;
endpackage

// File: rtl/lc3_agu_ctl.sv
module lc3_agu_ctl
  import lc3_agu_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  output agu_ctl_t         ctl_o
);
  instr_cls_e cls;
  assign cls = instr_cls_e'(cls_i);

  always_comb begin
    ctl_o = '{dr_link: 1'b0, sr1_hi: 1'b0, base_reg: 1'b0, ofs: OFS_ZERO,
              mar_vec: 1'b0, mar_en: 1'b0, pc_ld: 1'b0};
    unique case (cls)
      CLS_BR: begin
        ctl_o.ofs   = OFS_9;
        ctl_o.pc_ld = 1'b1;
      end
      CLS_JMP: begin
        ctl_o.base_reg = 1'b1;
        ctl_o.pc_ld    = 1'b1;
      end
      CLS_JSR: begin
        ctl_o.dr_link = 1'b1;
        ctl_o.ofs     = OFS_11;
        ctl_o.pc_ld   = 1'b1;
      end
      CLS_JSRR: begin
        ctl_o.dr_link  = 1'b1;
        ctl_o.base_reg = 1'b1;
        ctl_o.pc_ld    = 1'b1;
      end
      CLS_LD: begin
        ctl_o.ofs    = OFS_9;
        ctl_o.mar_en = 1'b1;
      end
      CLS_LDR, CLS_STR: begin
        ctl_o.base_reg = 1'b1;
        ctl_o.ofs      = OFS_6;
        ctl_o.mar_en   = 1'b1;
      end
      CLS_ST: begin
        ctl_o.sr1_hi = 1'b1;
        ctl_o.ofs    = OFS_9;
        ctl_o.mar_en = 1'b1;
      end
      CLS_TRAP: begin
        ctl_o.dr_link = 1'b1;
        ctl_o.mar_vec = 1'b1;
        ctl_o.mar_en  = 1'b1;
      end
      CLS_LEA: ctl_o.ofs = OFS_9;
      default: ;
    endcase
  end
endmodule

// File: rtl/lc3_reg_sel.sv
module lc3_reg_sel #(
  parameter int REG_W = 3
) (
  input  logic             link_i,
  input  logic             sr1_hi_i,
  input  logic [REG_W-1:0] fld_hi_i,
  input  logic [REG_W-1:0] fld_lo_i,
  output logic [REG_W-1:0] dr_o,
  output logic [REG_W-1:0] sr1_o
);
  localparam logic [REG_W-1:0] LINK_REG = '1;

  assign dr_o  = link_i   ? LINK_REG : fld_hi_i;
  assign sr1_o = sr1_hi_i ? fld_hi_i : fld_lo_i;
endmodule

// File: rtl/lc3_addr_gen.sv
module lc3_addr_gen
  import lc3_agu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IMM_A  = 6,
  parameter int IMM_B  = 9,
  parameter int IMM_C  = 11,
  parameter int VEC_W  = 8
) (
  input  logic [IMM_C-1:0]  imm_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] reg_i,
  input  logic              base_reg_i,
  input  ofs_sel_e          ofs_i,
  input  logic              mar_vec_i,
  output logic [WORD_W-1:0] sum_o,
  output logic [WORD_W-1:0] mar_o
);
  localparam int N_OFS = 4;

  logic [WORD_W-1:0] ofs_ext [N_OFS];
  logic [WORD_W-1:0] base;
  logic [WORD_W-1:0] vec_ext;

  assign ofs_ext[0] = '0;

  for (genvar g = 1; g < N_OFS; g++) begin : g_sext
    localparam int W = (g == 1) ? IMM_A : (g == 2) ? IMM_B : IMM_C;
    assign ofs_ext[g] = {{(WORD_W-W){imm_i[W-1]}}, imm_i[W-1:0]};
  end

  assign base    = base_reg_i ? reg_i : pc_i;
  assign sum_o   = base + ofs_ext[ofs_i];
  assign vec_ext = {{(WORD_W-VEC_W){1'b0}}, imm_i[VEC_W-1:0]};
  assign mar_o   = mar_vec_i ? vec_ext : sum_o;
endmodule

// File: rtl/lc3_agu.sv
module lc3_agu
  import lc3_agu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int REG_W  = 3
) (
  input  logic [CLS_W-1:0]  cls_i,
  input  logic [WORD_W-1:0] ir_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] sr1_val_i,
  output logic [REG_W-1:0]  dr_o,
  output logic [REG_W-1:0]  sr1_o,
  output logic              dr_sel_o,
  output logic              sr1_sel_o,
  output logic              base_sel_o,
  output logic [1:0]        ofs_sel_o,
  output logic              mar_sel_o,
  output logic [WORD_W-1:0] sum_o,
  output logic [WORD_W-1:0] mar_addr_o,
  output logic              mar_en_o,
  output logic              pc_ld_o
);
  localparam int HI_LSB = 9;
  localparam int LO_LSB = 6;
  localparam int IMM_C  = 11;
  localparam int OPC_LSB = 12;

  agu_ctl_t ctl;
  logic     unused_opc;

  assign unused_opc = ^ir_i[WORD_W-1:OPC_LSB];

  lc3_agu_ctl u_ctl (
    .cls_i (cls_i),
    .ctl_o (ctl)
  );

  lc3_reg_sel #(.REG_W(REG_W)) u_reg_sel (
    .link_i   (ctl.dr_link),
    .sr1_hi_i (ctl.sr1_hi),
    .fld_hi_i (ir_i[HI_LSB +: REG_W]),
    .fld_lo_i (ir_i[LO_LSB +: REG_W]),
    .dr_o     (dr_o),
    .sr1_o    (sr1_o)
  );

  lc3_addr_gen #(.WORD_W(WORD_W), .IMM_C(IMM_C)) u_addr (
    .imm_i      (ir_i[IMM_C-1:0]),
    .pc_i       (pc_i),
    .reg_i      (sr1_val_i),
    .base_reg_i (ctl.base_reg),
    .ofs_i      (ctl.ofs),
    .mar_vec_i  (ctl.mar_vec),
    .sum_o      (sum_o),
    .mar_o      (mar_addr_o)
  );

  assign dr_sel_o   = ctl.dr_link;
  assign sr1_sel_o  = ctl.sr1_hi;
  assign base_sel_o = ctl.base_reg;
  assign ofs_sel_o  = ctl.ofs;
  assign mar_sel_o  = ctl.mar_vec;
  assign mar_en_o   = ctl.mar_en;
  assign pc_ld_o    = ctl.pc_ld;
endmodule

// File: rtl/lc3_agu_chk.sv
module lc3_agu_chk #(
  parameter int WORD_W = 16,
  parameter int REG_W  = 3
) (
  input logic [3:0]        cls_i,
  input logic [WORD_W-1:0] ir_i,
  input logic [WORD_W-1:0] pc_i,
  input logic [WORD_W-1:0] sr1_val_i,
  input logic [REG_W-1:0]  dr_o,
  input logic [REG_W-1:0]  sr1_o,
  input logic              dr_sel_o,
  input logic              sr1_sel_o,
  input logic              base_sel_o,
  input logic [1:0]        ofs_sel_o,
  input logic              mar_sel_o,
  input logic [WORD_W-1:0] sum_o,
  input logic [WORD_W-1:0] mar_addr_o,
  input logic              mar_en_o,
  input logic              pc_ld_o
);
  always_comb begin
    assert_one_path_R7: assert (!(mar_en_o && pc_ld_o))
      else $error("memory and PC paths enabled together");
    assert_dr_link_R1: assert (!dr_sel_o || dr_o == '1)
      else $error("link select without R7");
    assert_dr_field_R1: assert (dr_sel_o || dr_o == ir_i[11:9])
      else $error("destination field mismatch");
    assert_sr1_field_R2: assert (sr1_o == (sr1_sel_o ? ir_i[11:9] : ir_i[8:6]))
      else $error("source field mismatch");
    assert_zero_ofs_R5: assert (ofs_sel_o != 2'd0 ||
                                sum_o == (base_sel_o ? sr1_val_i : pc_i))
      else $error("zero offset sum mismatch");
    assert_vec_R6: assert (!mar_sel_o ||
                           mar_addr_o == {{(WORD_W-8){1'b0}}, ir_i[7:0]})
      else $error("trap vector mismatch");
    assert_mar_sum_R6: assert (mar_sel_o || mar_addr_o == sum_o)
      else $error("memory address not the sum");
    assert_idle_R8: assert (!(cls_i == 4'd0 || cls_i > 4'd9) || !(mar_en_o || pc_ld_o))
      else $error("idle class raised an enable");
  end
endmodule

bind lc3_agu lc3_agu_chk #(.WORD_W(WORD_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/tb_lc3_agu.sv
module tb_lc3_agu;
  localparam int W = 16;
  localparam int NV = 14;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]   cls_i;
  logic [W-1:0] ir_i, pc_i, sr1_val_i;
  logic [2:0]   dr_o, sr1_o;
  logic         dr_sel_o, sr1_sel_o, base_sel_o, mar_sel_o, mar_en_o, pc_ld_o;
  logic [1:0]   ofs_sel_o;
  logic [W-1:0] sum_o, mar_addr_o;

  lc3_agu dut (.*);

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // cls, ir, pc, sr1val, dr, sr1, sels{dr,sr1,base,ofs[1:0],mar}, en{mar,pc}, sum, mar
  localparam logic [97:0] VEC [NV] = '{
    {4'd0,  16'h1283, 16'h3001, 16'h1111, 3'd1, 3'd2, 6'b000000, 2'b00, 16'h3001, 16'h3001},
    {4'd1,  16'h0939, 16'h30EC, 16'h1111, 3'd4, 3'd4, 6'b000100, 2'b01, 16'h3025, 16'h3025},
    {4'd2,  16'hC1C0, 16'h3000, 16'h4321, 3'd0, 3'd7, 6'b001000, 2'b01, 16'h4321, 16'h4321},
    {4'd3,  16'h4BFF, 16'h3000, 16'h1111, 3'd7, 3'd7, 6'b100110, 2'b01, 16'h33FF, 16'h33FF},
    {4'd3,  16'h4C00, 16'h0100, 16'h1111, 3'd7, 3'd0, 6'b100110, 2'b01, 16'hFD00, 16'hFD00},
    {4'd4,  16'h4080, 16'h3000, 16'hBEEF, 3'd7, 3'd2, 6'b101000, 2'b01, 16'hBEEF, 16'hBEEF},
    {4'd5,  16'h25FF, 16'h3005, 16'h1111, 3'd2, 3'd7, 6'b000100, 2'b10, 16'h3004, 16'h3004},
    {4'd6,  16'h6A9F, 16'h3000, 16'hFFF0, 3'd5, 3'd2, 6'b001010, 2'b10, 16'h000F, 16'h000F},
    {4'd7,  16'h3620, 16'h4000, 16'h1111, 3'd3, 3'd3, 6'b010100, 2'b10, 16'h4020, 16'h4020},
    {4'd8,  16'h72A0, 16'h3000, 16'h5000, 3'd1, 3'd2, 6'b001010, 2'b10, 16'h4FE0, 16'h4FE0},
    {4'd9,  16'hF025, 16'h3010, 16'h1111, 3'd7, 3'd0, 6'b100001, 2'b10, 16'h3010, 16'h0025},
    {4'd9,  16'hF0FF, 16'h3010, 16'h1111, 3'd7, 3'd3, 6'b100001, 2'b10, 16'h3010, 16'h00FF},
    {4'd10, 16'hE3FE, 16'h3001, 16'h1111, 3'd1, 3'd7, 6'b000100, 2'b00, 16'h2FFF, 16'h2FFF},
    {4'd15, 16'h3620, 16'h4000, 16'h1111, 3'd3, 3'd0, 6'b000000, 2'b00, 16'h4000, 16'h4000}
  };

  task automatic check(input string req, input string what, input int idx,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s case %0d %s: got %h exp %h", req, idx, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [W-1:0] ir,
                       input logic [W-1:0] pc, input logic [W-1:0] rv);
    @(posedge clk);
    cls_i = c; ir_i = ir; pc_i = pc; sr1_val_i = rv;
    @(negedge clk);
  endtask

  initial begin
    cls_i = '0; ir_i = '0; pc_i = '0; sr1_val_i = '0;
    @(negedge clk);
    // all-zero inputs: ALU class, nothing enabled
    check("R8", "idle en", 0, {14'd0, mar_en_o, pc_ld_o}, 16'd0);
    check("R5", "idle sum", 0, sum_o, 16'h0000);
    check("R1", "idle dr", 0, {13'd0, dr_o}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [97:0] v;
      v = VEC[i];
      apply(v[97:94], v[93:78], v[77:62], v[61:46]);
      check("R1", "dr", i, {13'd0, dr_o}, {13'd0, v[45:43]});
      check("R2", "sr1", i, {13'd0, sr1_o}, {13'd0, v[42:40]});
      check("R1", "dr_sel", i, {15'd0, dr_sel_o}, {15'd0, v[39]});
      check("R2", "sr1_sel", i, {15'd0, sr1_sel_o}, {15'd0, v[38]});
      check("R3", "base_sel", i, {15'd0, base_sel_o}, {15'd0, v[37]});
      check("R4", "ofs_sel", i, {14'd0, ofs_sel_o}, {14'd0, v[36:35]});
      check("R6", "mar_sel", i, {15'd0, mar_sel_o}, {15'd0, v[34]});
      check("R7", "enables", i, {14'd0, mar_en_o, pc_ld_o}, {14'd0, v[33:32]});
      check("R5", "sum", i, sum_o, v[31:16]);
      check("R6", "mar_addr", i, mar_addr_o, v[15:0]);
    end

    // JSRR: sum follows the register value alone
    apply(4'd4, 16'h4080, 16'h3000, 16'h0000);
    check("R3", "jsrr zero base", 100, sum_o, 16'h0000);
    apply(4'd4, 16'h4080, 16'h1234, 16'hFFFF);
    check("R3", "jsrr max base", 101, sum_o, 16'hFFFF);
    // LDR with most negative 6-bit offset from zero base wraps
    apply(4'd6, 16'h6020, 16'h3000, 16'h0000);
    check("R5", "ldr wrap", 102, sum_o, 16'hFFE0);
    // BR with most positive 9-bit offset near top wraps
    apply(4'd1, 16'h00FF, 16'hFF80, 16'h0000);
    check("R5", "br wrap", 103, sum_o, 16'h007F);
    // undefined codes 11..15 never enable either path
    for (int c = 11; c < 16; c++) begin
      apply(c[3:0], 16'h2FFF, 16'h3000, 16'h5555);
      check("R8", "undef en", 200 + c, {14'd0, mar_en_o, pc_ld_o}, 16'd0);
      check("R8", "undef sum", 200 + c, sum_o, 16'h3000);
    end
    // LEA: address formed but no enable
    apply(4'd10, 16'hE1FF, 16'h0000, 16'h0000);
    check("R8", "lea en", 300, {14'd0, mar_en_o, pc_ld_o}, 16'd0);
    check("R5", "lea sum", 300, sum_o, 16'hFFFF);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule